// File: doc/BRIEF.md
# Breaker pole-discordance detector

This block watches the per-pole auxiliary contact status of one or two three-pole circuit breakers. Each contact bit reads 1 when that pole is closed. When the three poles of a breaker are not all in the same position, the block raises a discordance flag for that breaker. Typical causes are a stuck pole, or a pole left open after a single-pole operation that never completed. Downstream logic may use the flag to raise an alarm or to trip.

During a deliberate single-pole open interval the poles are expected to disagree. For that reason checking is suspended while the single-pole trip input is high. When that input falls, a supervision delay counted in cycle ticks starts. A new falling edge during the delay restarts it from zero. Once the delay has run out, a disagreement raises the flag on the next clock, with no further timing. The contact inputs are resynchronised through two flops before they are compared.

Top module: `poleDiscordDet`

## Requirements
- R1: Each contact input passes through a two-flop synchroniser. A change on a contact input, applied before clock edge k, first affects the flags at edge k+2.
- R2: While checking is enabled, pd1 is high on the clock after synchronised breaker 1 status is neither 3'b000 nor 3'b111.
- R3: While checking is enabled and secondEn is 1, pd2 is high on the clock after synchronised breaker 2 status is neither 3'b000 nor 3'b111.
- R4: When secondEn is 0, pd2 is low on the following clock, whatever breaker 2 reports.
- R5: While spTrip is 1, both flags are low from the next clock onward.
- R6: A falling edge of spTrip, seen at edge e, starts a delay of delaySetting ticks. With cycleTick held at 1, the flags stay low through edge e+delaySetting and may rise at edge e+delaySetting+1.
- R7: Only clocks with cycleTick at 1 advance the delay. Clocks without a tick leave checking suspended.
- R8: A new falling edge of spTrip while the delay is running restarts the delay from zero.
- R9: With delaySetting equal to 0, checking resumes on the clock after the edge at which the falling edge was seen.
- R10: A flag goes low on the clock after the synchronised status of its breaker is all 3'b000 or all 3'b111 again.
- R11: Synchronous reset (rst high) clears both flags, the delay timer and the synchronisers. After reset, checking is enabled at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| brk1Poles | input | 3 | Breaker 1 pole contacts (1 = pole closed) |
| brk2Poles | input | 3 | Breaker 2 pole contacts (1 = pole closed) |
| spTrip | input | 1 | Single-pole trip active |
| cycleTick | input | 1 | One-clock strobe per power-system cycle |
| delaySetting | input | DLY_W | Supervision delay in ticks |
| secondEn | input | 1 | Enables breaker 2 monitoring |
| pd1 | output | 1 | Breaker 1 discordance |
| pd2 | output | 1 | Breaker 2 discordance |

## Verification
Several properties are checked on every cycle:
- both flags are low after a trip cycle, after reset, and after a cycle in which the poles agree;
- pd2 is low after secondEn was low;
- the timer restarts at zero on every dropout and holds its count on clocks without a tick;
- a flag can only rise after a cycle in which checking was enabled and the poles disagreed.

The exact number of clocks from a dropout to the first possible rise, the restart of the delay partway through, and the synchroniser latency can only be shown by the bench's timed scenarios. The same holds for a reset that cuts off a running delay.

// File: rtl/pdd_pkg.sv
package pdd_pkg;
  typedef struct packed {
    logic checkEn;
  } pddStrobe_t;

  localparam int POLES = 3;
endpackage

// File: rtl/bitSync.sv
module bitSync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= din;
      stage2 <= stage1;
    end
  end

  assign dout = stage2;
endmodule

// File: rtl/pddCtrl.sv
module pddCtrl
  import pdd_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spTrip,
  input  logic             cycleTick,
  input  logic [DLY_W-1:0] delaySetting,
  output pddStrobe_t       strobe
);
  localparam int CNT_W = DLY_W + 1;

  logic             tripQ;
  logic             running;
  logic [DLY_W-1:0] tickCnt;
  logic             fallEdge;
  logic [CNT_W-1:0] nextCnt;
  logic             delayDone;

  assign fallEdge  = tripQ & ~spTrip;
  assign nextCnt   = {1'b0, tickCnt} + CNT_W'(1);
  assign delayDone = nextCnt >= {1'b0, delaySetting};

  always_ff @(posedge clk) begin
    if (rst) begin
      tripQ   <= 1'b0;
      running <= 1'b0;
      tickCnt <= '0;
    end else begin
      tripQ <= spTrip;
      if (fallEdge) begin
        tickCnt <= '0;
        running <= (delaySetting != '0);
      end else if (running && cycleTick) begin
        if (delayDone) begin
          running <= 1'b0;
          tickCnt <= '0;
        end else begin
          tickCnt <= nextCnt[DLY_W-1:0];
        end
      end
    end
  end

  always_comb begin
    strobe.checkEn = ~spTrip & ~running & ~fallEdge;
  end

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (fallEdge && delaySetting != '0) |=> (running && tickCnt == '0));

  // R9
  zeroDelay_chk: assert property (@(posedge clk) disable iff (rst)
    (fallEdge && delaySetting == '0) |=> !running);

  // R7
  noTickHold_chk: assert property (@(posedge clk) disable iff (rst)
    (running && !cycleTick && !fallEdge) |=> (running && $stable(tickCnt)));
endmodule

// File: rtl/pddDatapath.sv
module pddDatapath
  import pdd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [POLES-1:0] brk1Raw,
  input  logic [POLES-1:0] brk2Raw,
  input  logic             secondEn,
  input  pddStrobe_t       strobe,
  output logic             pd1,
  output logic             pd2
);
  logic [POLES-1:0] brk1Sync;
  logic [POLES-1:0] brk2Sync;
  logic             mismatch1;
  logic             mismatch2;

  bitSync #(.W(POLES)) u_sync1 (.clk(clk), .rst(rst), .din(brk1Raw), .dout(brk1Sync));
  bitSync #(.W(POLES)) u_sync2 (.clk(clk), .rst(rst), .din(brk2Raw), .dout(brk2Sync));

  function automatic logic polesDiffer(input logic [POLES-1:0] p);
    return !((p == '0) || (p == '1));
  endfunction

  assign mismatch1 = polesDiffer(brk1Sync);
  assign mismatch2 = polesDiffer(brk2Sync);

  always_ff @(posedge clk) begin
    if (rst) begin
      pd1 <= 1'b0;
      pd2 <= 1'b0;
    end else begin
      pd1 <= strobe.checkEn & mismatch1;
      pd2 <= strobe.checkEn & secondEn & mismatch2;
    end
  end

  // R2
  pd1Cause_chk: assert property (@(posedge clk) disable iff (rst)
    pd1 |-> $past(strobe.checkEn && mismatch1));

  // R10
  agreeDrop_chk: assert property (@(posedge clk) disable iff (rst)
    (!mismatch1) |=> !pd1);

  // R4
  pd2Gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!secondEn) |=> !pd2);
endmodule

// File: rtl/poleDiscordDet.sv
module poleDiscordDet
  import pdd_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       brk1Poles,
  input  logic [2:0]       brk2Poles,
  input  logic             spTrip,
  input  logic             cycleTick,
  input  logic [DLY_W-1:0] delaySetting,
  input  logic             secondEn,
  output logic             pd1,
  output logic             pd2
);
  pddStrobe_t strobe;

  pddCtrl #(.DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rst(rst), .spTrip(spTrip), .cycleTick(cycleTick),
    .delaySetting(delaySetting), .strobe(strobe)
  );

  pddDatapath u_dp (
    .clk(clk), .rst(rst), .brk1Raw(brk1Poles), .brk2Raw(brk2Poles),
    .secondEn(secondEn), .strobe(strobe), .pd1(pd1), .pd2(pd2)
  );

  // R5
  tripHold_chk: assert property (@(posedge clk) disable iff (rst)
    spTrip |=> (!pd1 && !pd2));

  // R11
  resetClr_chk: assert property (@(posedge clk)
    rst |=> (!pd1 && !pd2));
endmodule

// File: tb/sim_poleDiscordDet.sv
module sim_poleDiscordDet;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] b1, b2;
  logic       spTrip, tick, en;
  logic [7:0] dly;
  logic       pd1, pd2;
  int         checks = 0;
  int         fails = 0;

  poleDiscordDet #(.DLY_W(8)) u0 (
    .clk(clk), .rst(rst), .brk1Poles(b1), .brk2Poles(b2), .spTrip(spTrip),
    .cycleTick(tick), .delaySetting(dly), .secondEn(en), .pd1(pd1), .pd2(pd2)
  );

  always #10 clk = ~clk;

  // fields: [8:6] b1, [5:3] b2, [2] en, [1] expected pd1, [0] expected pd2
  localparam logic [8:0] VEC [9] = '{
    {3'b000, 3'b000, 1'b1, 1'b0, 1'b0},
    {3'b111, 3'b111, 1'b1, 1'b0, 1'b0},
    {3'b001, 3'b000, 1'b1, 1'b1, 1'b0},
    {3'b000, 3'b110, 1'b1, 1'b0, 1'b1},
    {3'b101, 3'b011, 1'b1, 1'b1, 1'b1},
    {3'b101, 3'b011, 1'b0, 1'b1, 1'b0},
    {3'b111, 3'b100, 1'b0, 1'b0, 1'b0},
    {3'b011, 3'b111, 1'b1, 1'b1, 1'b0},
    {3'b100, 3'b010, 1'b1, 1'b1, 1'b1}
  };

  task automatic stepN(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; b1 = 3'b001; b2 = 3'b011; spTrip = 1'b0; tick = 1'b1;
    en = 1'b1; dly = 8'd0;
    stepN(3);
    check("R11 pd1 in reset", pd1, 1'b0);
    check("R11 pd2 in reset", pd2, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < 9; i++) begin
      b1 = VEC[i][8:6]; b2 = VEC[i][5:3]; en = VEC[i][2];
      stepN(3);
      check($sformatf("R2 vector %0d pd1", i), pd1, VEC[i][1]);
      check($sformatf("R3 vector %0d pd2", i), pd2, VEC[i][0]);
    end

    b1 = 3'b111;
    stepN(2);
    check("R1 pd1 before sync latency", pd1, 1'b1);
    stepN(1);
    check("R10 pd1 clears after agree", pd1, 1'b0);

    en = 1'b0;
    stepN(1);
    check("R4 pd2 gated by secondEn", pd2, 1'b0);
    en = 1'b1;
    stepN(1);
    check("R3 pd2 returns with secondEn", pd2, 1'b1);

    b1 = 3'b010;
    stepN(3);
    check("R2 pd1 raised", pd1, 1'b1);
    spTrip = 1'b1;
    stepN(1);
    check("R5 pd1 held during trip", pd1, 1'b0);
    check("R5 pd2 held during trip", pd2, 1'b0);
    stepN(3);

    dly = 8'd4;
    spTrip = 1'b0;
    stepN(5);
    check("R6 pd1 low through delay", pd1, 1'b0);
    stepN(1);
    check("R6 pd1 after delay", pd1, 1'b1);

    dly = 8'd3; spTrip = 1'b1;
    stepN(2);
    tick = 1'b0; spTrip = 1'b0;
    stepN(10);
    check("R7 no ticks keeps hold", pd1, 1'b0);
    tick = 1'b1;
    stepN(3);
    check("R7 pd1 low until last tick", pd1, 1'b0);
    stepN(1);
    check("R7 pd1 after ticks", pd1, 1'b1);

    dly = 8'd5; spTrip = 1'b1;
    stepN(2);
    spTrip = 1'b0;
    stepN(3);
    spTrip = 1'b1;
    stepN(1);
    check("R8 held by repeat trip", pd1, 1'b0);
    spTrip = 1'b0;
    stepN(6);
    check("R8 delay restarted", pd1, 1'b0);
    stepN(1);
    check("R8 pd1 after restarted delay", pd1, 1'b1);

    dly = 8'd0; spTrip = 1'b1;
    stepN(2);
    spTrip = 1'b0;
    stepN(1);
    check("R9 dropout clock still held", pd1, 1'b0);
    stepN(1);
    check("R9 zero delay resumes", pd1, 1'b1);

    dly = 8'd10; spTrip = 1'b1;
    stepN(2);
    spTrip = 1'b0;
    stepN(2);
    rst = 1'b1;
    stepN(1);
    check("R11 reset clears pd1", pd1, 1'b0);
    rst = 1'b0;
    stepN(3);
    check("R11 reset clears timer", pd1, 1'b1);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule